// File: doc/BRIEF.md
# SPI Byte Slave with Receive Buffer

This block is a byte-wide serial peripheral interface slave that runs entirely in the system clock domain. It does not use SCK as a clock. SCK, MOSI and the active-low select are each passed through a two-flop synchronizer. SCK edges are found by comparing the synchronized level with its value one cycle earlier. The clock polarity and phase inputs select any of the four usual transfer modes. The block drives MISO only while it is selected and enabled, and it raises an output-enable for the pad.

The transmit side has a single buffer. A host write loads the next byte straight into the outgoing shift register, and only while no byte is in flight. The receive side has a double buffer. When a byte completes it is copied from the inbound shift register into a holding register, which the host reads at leisure. Three sticky flags report the following events:

- a completed byte;
- a host write refused because a byte was mid-shift;
- a completed byte that overwrote an unread one.

A one-cycle host read pulse clears all three flags.

Correct sampling needs the system clock to run at least four times faster than SCK.

Top module: `spi_slave_top`

## Requirements
- R1: While reset is held and just after it, all three flags read 0, `misoOe` and `misoOut` are 0, and `rxData` is 0.
- R2: The following stimulus leaves the flags unchanged, and `misoOe` and `misoOut` stay 0:
  - SCK and MOSI activity while `ssN` is high;
  - SCK and MOSI activity while `cfgEnable` is 0.
- R3: With `cfgCpha`=0, bit 7 of the loaded transmit byte appears on `misoOut` with `misoOe`=1 within four system clocks of `ssN` falling, before any SCK edge. The slave captures MOSI on each idle-to-active SCK edge and advances MISO on each active-to-idle edge.
- R4: With `cfgCpha`=1, `misoOe` stays 0 after `ssN` falls until the first idle-to-active SCK edge. From that edge on, bit 7 is driven. MOSI is captured on active-to-idle edges and MISO advances on every later idle-to-active edge.
- R5: In all four polarity/phase combinations (idle SCK level equal to `cfgCpol`), after eight capture edges the following hold, both bytes running most significant bit first:
  - `rxData` equals the eight MOSI bits;
  - `doneFlag` is 1;
  - the bits seen on MISO equal the transmit byte.
- R6: If `ssN` rises before the eighth capture edge, the partial byte is discarded and `doneFlag` is not set. The next selection starts again from bit 7 in both directions.
- R7: A byte completing while `doneFlag` is still 1 sets `overrunFlag`, and `rxData` then holds the newer byte.
- R8: A host write while a byte is being shifted sets `collisionFlag`. The written value is discarded and the byte in flight continues unchanged on MISO.
- R9: A one-cycle `hostRdEn` pulse clears `doneFlag`, `overrunFlag` and `collisionFlag` in the following cycle.
- R10: A host write while no byte is in flight, including between back-to-back bytes with `ssN` held or released, becomes the next transmitted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgEnable | input | 1 | Slave enable |
| cfgCpol | input | 1 | Idle level of SCK |
| cfgCpha | input | 1 | 0: capture on leading edge; 1: capture on trailing edge |
| sckIn | input | 1 | Serial clock from master (asynchronous) |
| mosiIn | input | 1 | Serial data from master (asynchronous) |
| ssN | input | 1 | Active-low select (asynchronous) |
| misoOut | output | 1 | Serial data to master, 0 when not driven |
| misoOe | output | 1 | Output enable for the MISO pad |
| hostWrEn | input | 1 | Host write strobe for the transmit byte |
| hostWrData | input | 8 | Transmit byte |
| hostRdEn | input | 1 | Host read strobe, clears the flags |
| rxData | output | 8 | Receive buffer contents |
| doneFlag | output | 1 | A byte has completed since the last read |
| collisionFlag | output | 1 | A host write was refused mid-byte |
| overrunFlag | output | 1 | An unread byte was overwritten |

## Verification
The hardest situation to reach is a host write that lands in the middle of a byte. The write must be refused, yet the transfer around it must stay intact. The bench reaches it by forking the serial master model against a host write timed forty clocks into the byte. It then compares the bits collected from MISO with the byte loaded before selection.

The abort case is also awkward: select rises after a few bits, and the bit counter must restart. It is exposed by running a full byte right after the abort. A counter that kept its old position would finish early and deliver a shifted value.

The bulk of the stimulus is a sweep of sixteen computed byte pairs through each of the four polarity/phase modes.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;

  // Strobes from the control FSM to the datapath, valid for one system clock.
  typedef struct packed {
    logic clearShift;   // deselected: drop any partial inbound byte
    logic captureBit;   // shift MOSI into the inbound register
    logic shiftTx;      // advance the outbound register by one bit
    logic byteDone;     // this capture completes the byte
  } ctlStrobes_t;

endpackage

// File: rtl/spi_slave_ctrl.sv
module spi_slave_ctrl
  import spi_slave_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgEnable,
  input  logic        cfgCpol,
  input  logic        cfgCpha,
  input  logic        sckIn,
  input  logic        mosiIn,
  input  logic        ssN,
  output ctlStrobes_t strobes,
  output logic        mosiBit,
  output logic        inByte,
  output logic        driveOk
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [SYNC_STAGES-1:0] sckPipe, mosiPipe, ssPipe;
  logic sckSync, ssSync, sckPrev;
  logic [CNT_W-1:0] bitCnt;
  logic selected, sckAct, prevAct, leadEdge, trailEdge, captureEdge, launchEdge;

  // Synchronizers: bit 0 takes the pin, the top bit is the usable level.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPipe  <= '0;
      mosiPipe <= '0;
      ssPipe   <= '1;
    end else begin
      sckPipe  <= {sckPipe[SYNC_STAGES-2:0], sckIn};
      mosiPipe <= {mosiPipe[SYNC_STAGES-2:0], mosiIn};
      ssPipe   <= {ssPipe[SYNC_STAGES-2:0], ssN};
    end
  end

  assign sckSync = sckPipe[SYNC_STAGES-1];
  assign ssSync  = ssPipe[SYNC_STAGES-1];
  assign mosiBit = mosiPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sckPrev <= 1'b0;
    else       sckPrev <= sckSync;
  end

  assign selected    = cfgEnable & ~ssSync;
  assign sckAct      = sckSync ^ cfgCpol;
  assign prevAct     = sckPrev ^ cfgCpol;
  assign leadEdge    = sckAct & ~prevAct;
  assign trailEdge   = ~sckAct & prevAct;
  assign captureEdge = cfgCpha ? trailEdge : leadEdge;
  assign launchEdge  = cfgCpha ? leadEdge : trailEdge;

  always_comb begin
    strobes.clearShift = ~selected;
    strobes.captureBit = selected & captureEdge;
    strobes.byteDone   = selected & captureEdge & (bitCnt == LAST_BIT);
    // No launch at bit position 0: the MSB is already on MISO.
    strobes.shiftTx    = selected & launchEdge & (bitCnt != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      inByte <= 1'b0;
    end else if (!selected) begin
      bitCnt <= '0;
      inByte <= 1'b0;
    end else begin
      if (strobes.captureBit)
        bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
      if (strobes.byteDone)
        inByte <= 1'b0;
      else if (leadEdge)
        inByte <= 1'b1;
    end
  end

  assign driveOk = selected & (~cfgCpha | inByte);

endmodule

// File: rtl/spi_slave_dp.sv
module spi_slave_dp
  import spi_slave_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic              mosiBit,
  input  logic              inByte,
  input  logic              driveOk,
  input  logic              hostWrEn,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              hostRdEn,
  output logic              misoOut,
  output logic              misoOe,
  output logic [DATA_W-1:0] rxData,
  output logic              doneFlag,
  output logic              collisionFlag,
  output logic              overrunFlag
);

  logic [DATA_W-1:0] txShift, rxShift, rxBuf;
  logic [DATA_W-1:0] rxNext;

  assign rxNext = {rxShift[DATA_W-2:0], mosiBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   txShift <= '0;
    else if (hostWrEn && !inByte) txShift <= hostWrData;
    else if (strobes.shiftTx)     txShift <= {txShift[DATA_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   rxShift <= '0;
    else if (strobes.clearShift) rxShift <= '0;
    else if (strobes.captureBit) rxShift <= rxNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBuf         <= '0;
      doneFlag      <= 1'b0;
      overrunFlag   <= 1'b0;
      collisionFlag <= 1'b0;
    end else begin
      if (strobes.byteDone) rxBuf <= rxNext;

      if (strobes.byteDone)  doneFlag <= 1'b1;
      else if (hostRdEn)     doneFlag <= 1'b0;

      if (strobes.byteDone && doneFlag && !hostRdEn) overrunFlag <= 1'b1;
      else if (hostRdEn)                             overrunFlag <= 1'b0;

      if (hostWrEn && inByte) collisionFlag <= 1'b1;
      else if (hostRdEn)      collisionFlag <= 1'b0;
    end
  end

  assign rxData  = rxBuf;
  assign misoOe  = driveOk;
  assign misoOut = driveOk & txShift[DATA_W-1];

endmodule

// File: rtl/spi_slave_top.sv
module spi_slave_top
  import spi_slave_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic              cfgCpol,
  input  logic              cfgCpha,
  input  logic              sckIn,
  input  logic              mosiIn,
  input  logic              ssN,
  output logic              misoOut,
  output logic              misoOe,
  input  logic              hostWrEn,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              hostRdEn,
  output logic [DATA_W-1:0] rxData,
  output logic              doneFlag,
  output logic              collisionFlag,
  output logic              overrunFlag
);

  ctlStrobes_t strobes;
  logic mosiBit, inByte, driveOk;

  spi_slave_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgCpol(cfgCpol),
    .cfgCpha(cfgCpha), .sckIn(sckIn), .mosiIn(mosiIn), .ssN(ssN),
    .strobes(strobes), .mosiBit(mosiBit), .inByte(inByte), .driveOk(driveOk)
  );

  spi_slave_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .mosiBit(mosiBit),
    .inByte(inByte), .driveOk(driveOk), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdEn(hostRdEn), .misoOut(misoOut),
    .misoOe(misoOe), .rxData(rxData), .doneFlag(doneFlag),
    .collisionFlag(collisionFlag), .overrunFlag(overrunFlag)
  );

endmodule

// File: rtl/spi_slave_checker.sv
module spi_slave_checker (
  input logic clk,
  input logic rstN,
  input logic ssN,
  input logic cfgEnable,
  input logic hostWrEn,
  input logic hostRdEn,
  input logic misoOut,
  input logic misoOe,
  input logic doneFlag,
  input logic collisionFlag,
  input logic overrunFlag
);

  // R2: select high long enough to pass the synchronizer means no drive
  a_r2_no_drive_deselected: assert property (@(posedge clk) disable iff (!rstN)
    (ssN && $past(ssN) && $past(ssN, 2)) |-> !misoOe);

  // R2: disabled slave never drives
  a_r2_no_drive_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |-> !misoOe);

  // R2: undriven MISO is held low
  a_r2_quiet_when_undriven: assert property (@(posedge clk) disable iff (!rstN)
    !misoOe |-> !misoOut);

  // R5 / R6: a byte can only complete while the slave was selected
  a_r5_done_needs_select: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> !$past(ssN, 3));

  // R7: overrun only arises on top of an unread byte
  a_r7_overrun_after_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunFlag) |-> ($past(doneFlag) && doneFlag));

  // R8: collision only arises from a host write
  a_r8_collision_from_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(collisionFlag) |-> $past(hostWrEn));

  // R9: a read pulse leaves overrun clear
  a_r9_read_clears_overrun: assert property (@(posedge clk) disable iff (!rstN)
    hostRdEn |=> !overrunFlag);

endmodule

bind spi_slave_top spi_slave_checker u_chk (.*);

// File: tb/spi_slave_top_bench.sv
module spi_slave_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 0, rstN = 0;
  logic cfgEnable = 1, cfgCpol = 0, cfgCpha = 0;
  logic sckIn = 0, mosiIn = 0, ssN = 1;
  logic misoOut, misoOe;
  logic hostWrEn = 0, hostRdEn = 0;
  logic [7:0] hostWrData = 0;
  logic [7:0] rxData;
  logic doneFlag, collisionFlag, overrunFlag;

  int vectors = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_slave_top u_spi_slave_top (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hostWrite(input logic [7:0] d);
    hostWrData = d; hostWrEn = 1; ticks(1); hostWrEn = 0;
  endtask

  task automatic hostRead();
    hostRdEn = 1; ticks(1); hostRdEn = 0; ticks(1);
  endtask

  // Master model: clocks nbits of mo, collects MISO; checks start-of-byte drive.
  task automatic xfer(input logic [7:0] mo, input logic [7:0] expTx,
                      input int nbits, output logic [7:0] mi);
    mi = 0;
    sckIn = cfgCpol; ssN = 0; ticks(4);
    if (!cfgCpha)
      chk(misoOe && misoOut == expTx[7], "R3 msb at select", {misoOe, misoOut}, {1'b1, expTx[7]});
    else
      chk(!misoOe, "R4 no drive before first edge", misoOe, 0);
    ticks(HALF - 4);
    for (int b = 7; b >= 8 - nbits; b--) begin
      if (!cfgCpha) begin
        mosiIn = mo[b]; ticks(HALF);
        mi[b] = misoOut; sckIn = ~cfgCpol; ticks(HALF);
        sckIn = cfgCpol;
      end else begin
        sckIn = ~cfgCpol; mosiIn = mo[b]; ticks(HALF);
        mi[b] = misoOut; sckIn = cfgCpol; ticks(HALF);
      end
    end
    ticks(HALF); ssN = 1; ticks(4);
  endtask

  logic [7:0] got, t1, m1;

  initial begin
    ticks(3);
    chk(!doneFlag && !collisionFlag && !overrunFlag, "R1 flags in reset",
        {doneFlag, collisionFlag, overrunFlag}, 0);
    chk(!misoOe && !misoOut && rxData == 0, "R1 outputs in reset", {misoOe, misoOut, rxData}, 0);
    rstN = 1; ticks(2);
    chk(!doneFlag && !misoOe && rxData == 0, "R1 after reset", {doneFlag, misoOe, rxData}, 0);

    // R5 / R3 / R4 / R10 / R9: sweep of modes and byte pairs
    for (int mode = 0; mode < 4; mode++) begin
      cfgCpol = mode[1]; cfgCpha = mode[0];
      sckIn = cfgCpol; ticks(4);
      for (int i = 0; i < 16; i++) begin
        t1 = 8'((i * 37 + mode * 11 + 5) & 255);
        m1 = 8'(((i * 53) ^ 8'hC3) + mode);
        if (i == 0) begin t1 = 8'h00; m1 = 8'hFF; end
        if (i == 1) begin t1 = 8'hFF; m1 = 8'h00; end
        hostWrite(t1);
        xfer(m1, t1, 8, got);
        chk(rxData == m1, "R5 received byte", rxData, m1);
        chk(doneFlag, "R5 done flag", doneFlag, 1);
        chk(got == t1, "R5 R10 transmitted byte", got, t1);
        hostRead();
        chk(!doneFlag && !overrunFlag, "R9 read clears", {doneFlag, overrunFlag}, 0);
      end
    end

    // R2: deselected activity
    cfgCpol = 0; cfgCpha = 0; sckIn = 0; ssN = 1; ticks(4);
    for (int b = 0; b < 16; b++) begin
      mosiIn = b[0]; sckIn = ~sckIn; ticks(HALF);
      chk(!misoOe && !misoOut, "R2 deselected no drive", misoOe, 0);
    end
    chk(!doneFlag, "R2 deselected ignored", doneFlag, 0);

    // R2: disabled but selected
    cfgEnable = 0; sckIn = 0; ssN = 0; ticks(4);
    for (int b = 0; b < 16; b++) begin
      mosiIn = b[1]; sckIn = ~sckIn; ticks(HALF);
      chk(!misoOe && !misoOut, "R2 disabled no drive", misoOe, 0);
    end
    ssN = 1; ticks(4);
    chk(!doneFlag, "R2 disabled ignored", doneFlag, 0);
    cfgEnable = 1;

    // R6: abort mid-byte in two modes
    for (int mode = 0; mode < 2; mode++) begin
      cfgCpol = 0; cfgCpha = mode[0]; sckIn = 0; ticks(4);
      hostWrite(8'hB4);
      xfer(8'h5A, 8'hB4, 3, got);
      chk(!doneFlag, "R6 abort no done", doneFlag, 0);
      hostWrite(8'h69);
      xfer(8'hE1, 8'h69, 8, got);
      chk(rxData == 8'hE1, "R6 restart rx", rxData, 8'hE1);
      chk(got == 8'h69, "R6 restart tx", got, 8'h69);
      hostRead();
    end

    // R7: overrun
    cfgCpol = 1; cfgCpha = 1; sckIn = 1; ticks(4);
    hostWrite(8'h11); xfer(8'h3C, 8'h11, 8, got);
    chk(!overrunFlag, "R7 no overrun on first", overrunFlag, 0);
    hostWrite(8'h22); xfer(8'hC5, 8'h22, 8, got);
    chk(overrunFlag, "R7 overrun set", overrunFlag, 1);
    chk(rxData == 8'hC5, "R7 newer byte kept", rxData, 8'hC5);
    hostRead();
    chk(!overrunFlag && !doneFlag, "R9 read clears overrun", {overrunFlag, doneFlag}, 0);

    // R8: collision
    cfgCpol = 0; cfgCpha = 0; sckIn = 0; ticks(4);
    hostWrite(8'h9D);
    fork
      xfer(8'h47, 8'h9D, 8, got);
      begin ticks(40); hostWrite(8'h00); end
    join
    chk(collisionFlag, "R8 collision set", collisionFlag, 1);
    chk(got == 8'h9D, "R8 transfer undisturbed", got, 8'h9D);
    chk(rxData == 8'h47, "R8 rx undisturbed", rxData, 8'h47);
    hostWrite(8'h72);
    xfer(8'h0F, 8'h72, 8, got);
    chk(got == 8'h72, "R10 idle write accepted", got, 8'h72);
    hostRead();
    chk(!collisionFlag, "R9 read clears collision", collisionFlag, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      vectors++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule